// File: doc/BRIEF.md
# Host Controller Control Register

This block is the main control register of a serial-bus link controller. Host software reaches it over a simple register bus. A write strobe comes with a port select: one port sets bits and the other clears them. The register contents are always available on one read bus. A 1 in the write data acts on that bit position, and a 0 leaves it alone. Each live field has its own access rule. One field is loaded only from a configuration word and can only be cleared by software. Another can change only while two other fields are both 1.

The register drives the controller's static controls: data byte-swap enable, link power status, link enable and posted-write enable. It also runs the soft-reset handshake. Setting the soft-reset bit returns every field to its reset value and raises a flush request. The field with the configuration-loaded value is restored from the latched configuration word. The soft-reset bit stays set until the rest of the controller pulses a completion input.

Top module: `hc_ctrl_reg`

## Requirements
- R1: After hardware reset the read bus is 0x0000_0000, swap_en_o is 1, and lps_o, link_en_o, posted_wr_en_o and flush_req_o are 0.
- R2: On a write with bus_clr_sel_i=0 (set port), each 1 in bus_wdata_i sets that bit. With bus_clr_sel_i=1 (clear port), each 1 clears it. Zero bits leave bits unchanged. This applies to bit 30 (no-swap), bit 19 (link power), bit 18 (posted-write enable) and bit 17 (link enable), and the new value reads back after the write edge.
- R3: Bits 31, 29:24, 21:20 and 15:0 always read as zero, whatever is written.
- R4: swap_en_o is the inverse of bit 30, valid in the cycle after the write edge that changes bit 30.
- R5: lps_o equals bit 19, link_en_o equals bit 17 and posted_wr_en_o equals bit 18, all valid in the cycle after the write edge.
- R6: Bit 23 (PHY-programming permission) takes cfg_prg_phy_i when cfg_valid_i is 1. The clear port clears it. The set port has no effect on it.
- R7: A write to bit 22 (enhancement enable), on either port, takes effect only if bits 23 and 17 are both 1 before the write. Otherwise bit 22 keeps its value.
- R8: A set-port write with bit 16 = 1 sets bit 16 and raises flush_req_o in the next cycle. In the same cycle every other field returns to its reset value, except bit 23, which takes the latched configuration value.
- R9: While bit 16 is set, all host writes are ignored. Bit 16 and flush_req_o stay 1 until flush_done_i is seen at a clock edge, and both read 0 from the cycle after that edge.
- R10: The clear port has no effect on bit 16, and flush_done_i has no effect when no soft reset is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_valid_i | input | 1 | Load strobe for the configuration value |
| cfg_prg_phy_i | input | 1 | Configuration value for bit 23 |
| bus_we_i | input | 1 | Register write strobe |
| bus_clr_sel_i | input | 1 | 0 selects the set port, 1 selects the clear port |
| bus_wdata_i | input | 32 | Write data, one bit per register position |
| flush_done_i | input | 1 | Soft-reset completion pulse |
| bus_rdata_o | output | 32 | Current register value |
| swap_en_o | output | 1 | Byte-swap enable for packet data |
| lps_o | output | 1 | Link power status |
| link_en_o | output | 1 | Link enable |
| posted_wr_en_o | output | 1 | Posted-write enable |
| flush_req_o | output | 1 | Soft-reset flush request |

## Verification
Each field sits in a flop that feeds the read bus and its control output directly. A wrong field value therefore shows on bus_rdata_o and on the matching output one cycle after the write that caused it. A gating fault on bit 22 shows as a readback that differs right after a write while bit 23 or bit 17 is 0. A fault in the handshake state shows at flush_req_o and bit 16: either they drop before the completion pulse, or they stay high in the cycle after it. In both cases the fault is visible within one cycle.

// File: rtl/hcr_pkg.sv
package hcr_pkg;
  localparam int REG_W    = 32;
  localparam int B_NOSWAP = 30;
  localparam int B_PRGPHY = 23;
  localparam int B_ENH    = 22;
  localparam int B_LPS    = 19;
  localparam int B_PWE    = 18;
  localparam int B_LINK   = 17;
  localparam int B_SRST   = 16;

  localparam logic [REG_W-1:0] LIVE_MASK =
    (REG_W'(1) << B_NOSWAP) | (REG_W'(1) << B_PRGPHY) | (REG_W'(1) << B_ENH) |
    (REG_W'(1) << B_LPS)    | (REG_W'(1) << B_PWE)    | (REG_W'(1) << B_LINK) |
    (REG_W'(1) << B_SRST);

  typedef struct packed {
    logic noswap;
    logic prgphy;
    logic enh;
    logic lps;
    logic pwe;
    logic link;
  } hcr_fields_t;

  typedef struct packed {
    logic        srst;
    hcr_fields_t f;
  } hcr_req_t;
endpackage

// File: rtl/hcr_wr_decode.sv
module hcr_wr_decode
  import hcr_pkg::*;
(
  input  logic             we_i,
  input  logic             clr_sel_i,
  input  logic [REG_W-1:0] wdata_i,
  output hcr_req_t         set_o,
  output hcr_req_t         clr_o
);
  hcr_req_t pick;

  always_comb begin
    pick.srst     = wdata_i[B_SRST];
    pick.f.noswap = wdata_i[B_NOSWAP];
    pick.f.prgphy = wdata_i[B_PRGPHY];
    pick.f.enh    = wdata_i[B_ENH];
    pick.f.lps    = wdata_i[B_LPS];
    pick.f.pwe    = wdata_i[B_PWE];
    pick.f.link   = wdata_i[B_LINK];
  end

  assign set_o = (we_i && !clr_sel_i) ? pick : '0;
  assign clr_o = (we_i &&  clr_sel_i) ? pick : '0;
endmodule

// File: rtl/hcr_srst_ctl.sv
module hcr_srst_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic done_i,
  output logic busy_o
);
  logic busy_q, busy_d;

  always_comb begin
    if (busy_q) busy_d = !done_i;
    else        busy_d = start_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= busy_d;
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/hcr_field_next.sv
module hcr_field_next
  import hcr_pkg::*;
(
  input  hcr_fields_t cur_i,
  input  hcr_req_t    set_i,
  input  hcr_req_t    clr_i,
  input  logic        srst_start_i,
  input  logic        srst_busy_i,
  input  logic        cfg_valid_i,
  input  logic        cfg_bit_i,
  input  logic        shadow_i,
  output hcr_fields_t nxt_o
);
  logic enh_gate;
  assign enh_gate = cur_i.prgphy && cur_i.link;

  always_comb begin
    nxt_o = cur_i;
    if (srst_start_i || srst_busy_i) begin
      nxt_o        = '0;
      nxt_o.prgphy = shadow_i;
    end else begin
      nxt_o.noswap = set_i.f.noswap | (cur_i.noswap & ~clr_i.f.noswap);
      nxt_o.lps    = set_i.f.lps    | (cur_i.lps    & ~clr_i.f.lps);
      nxt_o.pwe    = set_i.f.pwe    | (cur_i.pwe    & ~clr_i.f.pwe);
      nxt_o.link   = set_i.f.link   | (cur_i.link   & ~clr_i.f.link);
      nxt_o.prgphy = cur_i.prgphy & ~clr_i.f.prgphy;
      if (enh_gate)
        nxt_o.enh = set_i.f.enh | (cur_i.enh & ~clr_i.f.enh);
    end
    if (cfg_valid_i) nxt_o.prgphy = cfg_bit_i;
  end
endmodule

// File: rtl/hc_ctrl_reg.sv
module hc_ctrl_reg
  import hcr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_valid_i,
  input  logic             cfg_prg_phy_i,
  input  logic             bus_we_i,
  input  logic             bus_clr_sel_i,
  input  logic [REG_W-1:0] bus_wdata_i,
  input  logic             flush_done_i,
  output logic [REG_W-1:0] bus_rdata_o,
  output logic             swap_en_o,
  output logic             lps_o,
  output logic             link_en_o,
  output logic             posted_wr_en_o,
  output logic             flush_req_o
);
  hcr_req_t    set_r, clr_r;
  hcr_fields_t fld_q, fld_d;
  logic        shadow_q, shadow_d;
  logic        busy, start;

  hcr_wr_decode u_dec (
    .we_i      (bus_we_i),
    .clr_sel_i (bus_clr_sel_i),
    .wdata_i   (bus_wdata_i),
    .set_o     (set_r),
    .clr_o     (clr_r)
  );

  assign start = set_r.srst && !busy;

  hcr_srst_ctl u_srst (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start),
    .done_i  (flush_done_i),
    .busy_o  (busy)
  );

  assign shadow_d = cfg_valid_i ? cfg_prg_phy_i : shadow_q;

  hcr_field_next u_nxt (
    .cur_i        (fld_q),
    .set_i        (set_r),
    .clr_i        (clr_r),
    .srst_start_i (start),
    .srst_busy_i  (busy),
    .cfg_valid_i  (cfg_valid_i),
    .cfg_bit_i    (cfg_prg_phy_i),
    .shadow_i     (shadow_d),
    .nxt_o        (fld_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fld_q    <= '0;
      shadow_q <= 1'b0;
    end else begin
      fld_q    <= fld_d;
      shadow_q <= shadow_d;
    end
  end

  always_comb begin
    bus_rdata_o           = '0;
    bus_rdata_o[B_NOSWAP] = fld_q.noswap;
    bus_rdata_o[B_PRGPHY] = fld_q.prgphy;
    bus_rdata_o[B_ENH]    = fld_q.enh;
    bus_rdata_o[B_LPS]    = fld_q.lps;
    bus_rdata_o[B_PWE]    = fld_q.pwe;
    bus_rdata_o[B_LINK]   = fld_q.link;
    bus_rdata_o[B_SRST]   = busy;
  end

  assign swap_en_o      = !fld_q.noswap;
  assign lps_o          = fld_q.lps;
  assign link_en_o      = fld_q.link;
  assign posted_wr_en_o = fld_q.pwe;
  assign flush_req_o    = busy;
endmodule

// File: rtl/hc_ctrl_reg_chk.sv
module hc_ctrl_reg_chk
  import hcr_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_valid_i,
  input logic             flush_done_i,
  input logic [REG_W-1:0] bus_rdata_o,
  input logic             swap_en_o,
  input logic             lps_o,
  input logic             link_en_o,
  input logic             posted_wr_en_o,
  input logic             flush_req_o
);
  a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata_o & ~LIVE_MASK) == '0);

  a_r4_swap_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    swap_en_o == !bus_rdata_o[B_NOSWAP]);

  a_r5_lps_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    lps_o == bus_rdata_o[B_LPS]);

  a_r6_prg_no_host_set: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_rdata_o[B_PRGPHY]) |-> ($past(cfg_valid_i) || flush_req_o));

  a_r7_enh_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bus_rdata_o[B_ENH]) |->
      ($past(bus_rdata_o[B_PRGPHY] && bus_rdata_o[B_LINK]) || flush_req_o));

  a_r8_quiet_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req_o |-> (!link_en_o && !posted_wr_en_o && !lps_o && bus_rdata_o[B_SRST]));

  a_r9_hold_until_done: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_req_o && !flush_done_i) |=> flush_req_o);

  a_r9_release_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_req_o && flush_done_i) |=> !flush_req_o);
endmodule

bind hc_ctrl_reg hc_ctrl_reg_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cfg_valid_i    (cfg_valid_i),
  .flush_done_i   (flush_done_i),
  .bus_rdata_o    (bus_rdata_o),
  .swap_en_o      (swap_en_o),
  .lps_o          (lps_o),
  .link_en_o      (link_en_o),
  .posted_wr_en_o (posted_wr_en_o),
  .flush_req_o    (flush_req_o)
);

// File: tb/hc_ctrl_reg_tb.sv
`timescale 1ns/1ps
module hc_ctrl_reg_tb;
  logic        clk, rst_n;
  logic        cfg_valid, cfg_bit, we, clr_sel, done;
  logic [31:0] wdata, rdata;
  logic        swap_en, lps, link_en, pwe, flush_req;
  int          n_chk, n_bad;

  hc_ctrl_reg u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_valid_i(cfg_valid), .cfg_prg_phy_i(cfg_bit),
    .bus_we_i(we), .bus_clr_sel_i(clr_sel), .bus_wdata_i(wdata),
    .flush_done_i(done), .bus_rdata_o(rdata), .swap_en_o(swap_en),
    .lps_o(lps), .link_en_o(link_en), .posted_wr_en_o(pwe), .flush_req_o(flush_req)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; clr_sel = sel; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic cfg_load(input logic v);
    @(negedge clk);
    cfg_valid = 1'b1; cfg_bit = v;
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  task automatic chk_outs(input string tag, input logic [31:0] e);
    chk({tag, " rdata"}, rdata, e);
    chk({tag, " swap_en"}, {31'b0, swap_en}, {31'b0, !e[30]});
    chk({tag, " lps"}, {31'b0, lps}, {31'b0, e[19]});
    chk({tag, " link_en"}, {31'b0, link_en}, {31'b0, e[17]});
    chk({tag, " posted_wr"}, {31'b0, pwe}, {31'b0, e[18]});
    chk({tag, " flush_req"}, {31'b0, flush_req}, {31'b0, e[16]});
  endtask

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] e;
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; cfg_valid = 0; cfg_bit = 0; we = 0; clr_sel = 0; wdata = '0; done = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_outs("R1 reset", 32'h0);

    // R2 R4 R5: set then clear each free field
    foreach (e[i]) begin
      if (i == 30 || i == 19 || i == 18 || i == 17) begin
        wr(1'b0, 32'h1 << i);
        chk_outs($sformatf("R2 R4 R5 set bit%0d", i), 32'h1 << i);
        wr(1'b1, 32'h1 << i);
        chk_outs($sformatf("R2 R4 R5 clr bit%0d", i), 32'h0);
      end
    end

    // R3: all ones except soft reset
    wr(1'b0, ~(32'h1 << 16));
    chk_outs("R3 set all", 32'h400E_0000);
    wr(1'b1, ~(32'h1 << 16));
    chk_outs("R3 clr all", 32'h0);

    // R6
    cfg_load(1'b1);
    chk("R6 cfg load", rdata, 32'h0080_0000);
    wr(1'b1, 32'h1 << 23);
    chk("R6 clear", rdata, 32'h0);
    wr(1'b0, 32'h1 << 23);
    chk("R6 set ignored", rdata, 32'h0);
    cfg_load(1'b1);

    // R7: gating sweep over (bit23, bit17)
    wr(1'b0, 32'h1 << 22);
    chk("R7 prg1 link0", rdata, 32'h0080_0000);
    wr(1'b0, 32'h1 << 17);
    wr(1'b0, 32'h1 << 22);
    chk("R7 prg1 link1", rdata, 32'h00C2_0000);
    wr(1'b1, 32'h1 << 23);
    wr(1'b1, 32'h1 << 22);
    chk("R7 prg0 link1 clr ignored", rdata, 32'h0042_0000);
    wr(1'b1, 32'h1 << 17);
    wr(1'b1, 32'h1 << 22);
    chk("R7 prg0 link0 clr ignored", rdata, 32'h0040_0000);

    // R8: soft reset; shadow is 1, bit23 currently 0
    wr(1'b0, 32'h400E_0000);
    chk("R8 preload", rdata, 32'h404E_0000);
    @(negedge clk);
    we = 1'b1; clr_sel = 1'b0; wdata = 32'h1 << 16;
    @(negedge clk);
    we = 1'b0; wdata = '0;
    chk_outs("R8 start", 32'h0081_0000);

    // R9 R10: hold, writes ignored
    wr(1'b0, 32'h4006_0000);
    chk_outs("R9 write ignored in reset", 32'h0081_0000);
    wr(1'b1, 32'h1 << 16);
    chk_outs("R10 clear port on bit16", 32'h0081_0000);
    repeat (3) @(negedge clk);
    chk_outs("R9 hold without done", 32'h0081_0000);
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    chk_outs("R9 release after done", 32'h0080_0000);

    // R10: stray done when idle
    wr(1'b0, 32'h1 << 17);
    @(negedge clk);
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    @(negedge clk);
    chk_outs("R10 idle done", 32'h0082_0000);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule